// File: doc/BRIEF.md
# Accumulator ALU with Half-Byte Carry

This block is the arithmetic and logic stage of a small accumulator datapath. One operand always comes from the working register W. The other, called B here, is chosen from either a file-register read value or an immediate literal. One opcode selects the operation: add, subtract, AND, OR, XOR, complement, increment, decrement, rotate left or right through carry, nibble swap, or a plain move of B or of W. The block returns the result and new Carry, Digit Carry and Zero values. It also returns one update-enable bit per flag, so the surrounding status logic knows which flags the operation owns.

W sits inside the block and cannot be reached as a file location. When an operation executes, a single destination bit decides where the result goes. It is either loaded into W on the clock edge, or it is offered for write-back to the file register through a write strobe. Subtraction computes B minus W. In subtraction both carry flags mean "no borrow", not "borrow".

Top module: `acc_alu8`

## Requirements
- R1: Opcode 1 (add) gives result = (W + B) mod 256. C is 1 when the sum exceeds 255. C, DC and Z are all updated.
- R2: DC is the carry from bit 3 into bit 4 for add (W[3:0] + B[3:0] > 15). For subtract, DC is 1 when no borrow leaves the low nibble (B[3:0] >= W[3:0]).
- R3: Opcode 2 (subtract) gives result = (B - W) mod 256. C is 1 exactly when B >= W as unsigned values. C, DC and Z are all updated.
- R4: For every opcode that updates Z, Z is 1 exactly when the 8-bit result is zero. Any flag an opcode does not update appears at its output equal to its input (c_in, dc_in, z_in).
- R5: Opcodes 3 (B AND W), 4 (B OR W), 5 (B XOR W) and 6 (NOT B) give the bitwise result and update only Z.
- R6: Opcodes 7 (B + 1) and 8 (B - 1) wrap modulo 256 and update only Z.
- R7: Opcode 9 (rotate left) gives {B[6:0], c_in} with new C = B[7]. Opcode 10 (rotate right) gives {c_in, B[7:1]} with new C = B[0]. Both update only C.
- R8: Opcode 11 swaps the nibbles of B. Opcode 12 outputs W. Opcode 0 and the unused codes 13 to 15 output B. None of these updates any flag, except opcode 0 (move B), which updates Z.
- R9: When use_lit is 1, B is lit_val. Otherwise B is file_val.
- R10: W resets to 0. On a clock edge with exec_en and dest_w both 1, W loads the result. Otherwise W keeps its value. file_we equals exec_en AND NOT dest_w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of W |
| op | input | 4 | Operation code |
| use_lit | input | 1 | 1 selects the literal as operand B |
| file_val | input | 8 | File-register read value |
| lit_val | input | 8 | Immediate literal |
| c_in | input | 1 | Current Carry flag |
| dc_in | input | 1 | Current Digit Carry flag |
| z_in | input | 1 | Current Zero flag |
| exec_en | input | 1 | Operation executes this cycle |
| dest_w | input | 1 | 1 writes the result to W, 0 to the file register |
| result | output | 8 | Operation result |
| c_out | output | 1 | Next Carry flag |
| dc_out | output | 1 | Next Digit Carry flag |
| z_out | output | 1 | Next Zero flag |
| upd_c | output | 1 | Operation owns Carry |
| upd_dc | output | 1 | Operation owns Digit Carry |
| upd_z | output | 1 | Operation owns Zero |
| file_we | output | 1 | Write strobe for file write-back |
| w_val | output | 8 | Current W contents |

## Verification
W is the only state in this block. A wrong W value shows on w_val one clock after the faulty load. It also shows at once in every operation that reads W, so a corrupted accumulator cannot hide for long. Flag faults are combinational and appear in the same cycle as the opcode. A half-byte carry taken from the wrong bit, or a borrow flag left uninverted, shows up as soon as the random operands straddle a nibble boundary or make B less than W. Directed cases pin down the equal-operand and all-ones boundaries.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_MOVB = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_IOR  = 4'd4,
    OP_XOR  = 4'd5,
    OP_COMB = 4'd6,
    OP_INCB = 4'd7,
    OP_DECB = 4'd8,
    OP_RLB  = 4'd9,
    OP_RRB  = 4'd10,
    OP_SWPB = 4'd11,
    OP_MOVW = 4'd12,
    OP_RSV0 = 4'd13,
    OP_RSV1 = 4'd14,
    OP_RSV2 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic dc;
    logic z;
  } flag_set_t;
endpackage

// File: rtl/acc_opnd_sel.sv
module acc_opnd_sel #(
  parameter int WIDTH = 8
) (
  input  logic             pick_lit,
  input  logic [WIDTH-1:0] file_in,
  input  logic [WIDTH-1:0] lit_in,
  output logic [WIDTH-1:0] opnd_b
);
  // R9: operand B source
  assign opnd_b = pick_lit ? lit_in : file_in;
endmodule

// File: rtl/acc_wreg.sv
module acc_wreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (load) q <= d;
  end

  assert_wreg_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d)));
  assert_wreg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [3:0]       op_code,
  input  logic [WIDTH-1:0] w_opnd,
  input  logic [WIDTH-1:0] b_opnd,
  input  logic             carry_in,
  output logic [WIDTH-1:0] res,
  output flag_set_t        flag_new,
  output flag_set_t        flag_upd
);
  localparam int NIB = WIDTH / 2;

  // {carry out of top bit, carry out of low half, sum}
  function automatic logic [WIDTH+1:0] add_dc(input logic [WIDTH-1:0] a,
                                              input logic [WIDTH-1:0] b,
                                              input logic cin);
    logic [NIB:0]   lo;
    logic [WIDTH:0] full;
    lo   = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
    full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    return {full[WIDTH], lo[NIB], full[WIDTH-1:0]};
  endfunction

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH+1:0] sum_add;
  logic [WIDTH+1:0] sum_sub;
  alu_op_e          op;

  assign op      = alu_op_e'(op_code);
  assign sum_add = add_dc(w_opnd, b_opnd, 1'b0);   // R1 R2
  assign sum_sub = add_dc(b_opnd, ~w_opnd, 1'b1);  // R2 R3: not-borrow

  always_comb begin
    res        = b_opnd;
    flag_new.c = carry_in;
    flag_new.dc = 1'b0;
    flag_upd   = '0;
    unique case (op)
      OP_MOVB: flag_upd.z = 1'b1;
      OP_ADD: begin
        res = sum_add[WIDTH-1:0];
        flag_new.c  = sum_add[WIDTH+1];
        flag_new.dc = sum_add[WIDTH];
        flag_upd    = '{c: 1'b1, dc: 1'b1, z: 1'b1};
      end
      OP_SUB: begin
        res = sum_sub[WIDTH-1:0];
        flag_new.c  = sum_sub[WIDTH+1];
        flag_new.dc = sum_sub[WIDTH];
        flag_upd    = '{c: 1'b1, dc: 1'b1, z: 1'b1};
      end
      OP_AND:  begin res = b_opnd & w_opnd; flag_upd.z = 1'b1; end
      OP_IOR:  begin res = b_opnd | w_opnd; flag_upd.z = 1'b1; end
      OP_XOR:  begin res = b_opnd ^ w_opnd; flag_upd.z = 1'b1; end
      OP_COMB: begin res = ~b_opnd;         flag_upd.z = 1'b1; end
      OP_INCB: begin res = b_opnd + ONE;    flag_upd.z = 1'b1; end
      OP_DECB: begin res = b_opnd - ONE;    flag_upd.z = 1'b1; end
      OP_RLB: begin
        res        = {b_opnd[WIDTH-2:0], carry_in};
        flag_new.c = b_opnd[WIDTH-1];
        flag_upd.c = 1'b1;
      end
      OP_RRB: begin
        res        = {carry_in, b_opnd[WIDTH-1:1]};
        flag_new.c = b_opnd[0];
        flag_upd.c = 1'b1;
      end
      OP_SWPB: res = {b_opnd[NIB-1:0], b_opnd[WIDTH-1:NIB]};
      OP_MOVW: res = w_opnd;
      default: res = b_opnd;
    endcase
    flag_new.z = (res == '0);  // R4
  end
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op,
  input  logic             use_lit,
  input  logic [WIDTH-1:0] file_val,
  input  logic [WIDTH-1:0] lit_val,
  input  logic             c_in,
  input  logic             dc_in,
  input  logic             z_in,
  input  logic             exec_en,
  input  logic             dest_w,
  output logic [WIDTH-1:0] result,
  output logic             c_out,
  output logic             dc_out,
  output logic             z_out,
  output logic             upd_c,
  output logic             upd_dc,
  output logic             upd_z,
  output logic             file_we,
  output logic [WIDTH-1:0] w_val
);
  localparam int NIB = WIDTH / 2;

  logic [WIDTH-1:0] b_opnd;
  logic             w_load;
  flag_set_t        f_new;
  flag_set_t        f_upd;

  acc_opnd_sel #(.WIDTH(WIDTH)) u_sel (
    .pick_lit(use_lit), .file_in(file_val), .lit_in(lit_val), .opnd_b(b_opnd));

  acc_alu_core #(.WIDTH(WIDTH)) u_core (
    .op_code(op), .w_opnd(w_val), .b_opnd(b_opnd), .carry_in(c_in),
    .res(result), .flag_new(f_new), .flag_upd(f_upd));

  assign w_load  = exec_en & dest_w;   // R10
  assign file_we = exec_en & ~dest_w;

  acc_wreg #(.WIDTH(WIDTH)) u_w (
    .clk(clk), .rst_n(rst_n), .load(w_load), .d(result), .q(w_val));

  // R4: un-owned flags pass through
  assign upd_c  = f_upd.c;
  assign upd_dc = f_upd.dc;
  assign upd_z  = f_upd.z;
  assign c_out  = f_upd.c  ? f_new.c  : c_in;
  assign dc_out = f_upd.dc ? f_new.dc : dc_in;
  assign z_out  = f_upd.z  ? f_new.z  : z_in;

  assert_sub_noborrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SUB) |-> (c_out == (b_opnd >= w_val)));
  assert_add_halfcarry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADD) |->
      (dc_out == (({1'b0, w_val[NIB-1:0]} + {1'b0, b_opnd[NIB-1:0]}) > (NIB+1)'((1 << NIB) - 1))));
  assert_logic_keeps_c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op inside {OP_AND, OP_IOR, OP_XOR, OP_COMB}) |-> (c_out == c_in && dc_out == dc_in));
  assert_rotl_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RLB) |-> (result[0] == c_in && c_out == b_opnd[WIDTH-1] && z_out == z_in));
  assert_swap_noflags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SWPB) |-> (c_out == c_in && dc_out == dc_in && z_out == z_in));
  assert_dest_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    file_we |=> $stable(w_val));
endmodule

// File: tb/tb_acc_alu8.sv
module tb_acc_alu8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] op = 4'd0;
  logic use_lit = 1'b0;
  logic [7:0] file_val = 8'd0, lit_val = 8'd0;
  logic c_in = 1'b0, dc_in = 1'b0, z_in = 1'b0;
  logic exec_en = 1'b0, dest_w = 1'b0;
  logic [7:0] result, w_val;
  logic c_out, dc_out, z_out, upd_c, upd_dc, upd_z, file_we;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] w_model = 8'd0;

  always #2 clk = ~clk;

  acc_alu8 dut (.*);

  function automatic string tag_of(int o);
    case (o)
      1: return "R1";
      2: return "R3";
      3, 4, 5, 6: return "R5";
      7, 8: return "R6";
      9, 10: return "R7";
      default: return "R8";
    endcase
  endfunction

  // {res[7:0], c, dc, z, uc, udc, uz}
  function automatic logic [13:0] model(int o, int w, int b, bit ci, bit dci, bit zi);
    int r; bit c, dc, uc, udc, uz;
    c = ci; dc = dci; uc = 0; udc = 0; uz = 1;
    case (o)
      1: begin r = (w + b) % 256; c = (w + b) > 255; dc = (w % 16 + b % 16) > 15; uc = 1; udc = 1; end
      2: begin r = (b - w + 256) % 256; c = b >= w; dc = (b % 16) >= (w % 16); uc = 1; udc = 1; end
      3: r = b & w;
      4: r = b | w;
      5: r = b ^ w;
      6: r = 255 - b;
      7: r = (b + 1) % 256;
      8: r = (b + 255) % 256;
      9: begin r = (b * 2) % 256 + int'(ci); c = b >= 128; uc = 1; uz = 0; end
      10: begin r = b / 2 + (ci ? 128 : 0); c = (b % 2) == 1; uc = 1; uz = 0; end
      11: begin r = (b % 16) * 16 + b / 16; uz = 0; end
      12: begin r = w; uz = 0; end
      0: r = b;
      default: begin r = b; uz = 0; end
    endcase
    return {8'(r), c, dc, uz ? (r == 0) : zi, uc, udc, uz};
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(int o, bit ul, int fv, int lv, bit ci, bit dci, bit zi, bit ex, bit dw);
    logic [13:0] e; int b; string t;
    @(negedge clk);
    op = 4'(o); use_lit = ul; file_val = 8'(fv); lit_val = 8'(lv);
    c_in = ci; dc_in = dci; z_in = zi; exec_en = ex; dest_w = dw;
    #1;
    b = ul ? lv : fv;
    e = model(o, int'(w_model), b, ci, dci, zi);
    t = tag_of(o);
    chk("R10", "w_val", w_val, w_model);
    chk(t, "result", result, e[13:6]);
    chk(o == 2 ? "R3" : t, "c_out", c_out, e[5]);
    chk("R2", "dc_out", dc_out, e[4]);
    chk("R4", "z_out", z_out, e[3]);
    chk("R4", "upd", {upd_c, upd_dc, upd_z}, e[2:0]);
    chk("R10", "file_we", file_we, ex & ~dw);
    if (ex && dw) w_model = e[13:6];
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R10", "reset w_val", w_val, 0);
    // R9: literal vs file selection, load W
    apply(0, 1, 8'h11, 8'h3C, 0, 0, 0, 1, 1);
    apply(0, 0, 8'hA5, 8'h3C, 0, 0, 1, 0, 0);
    // R1 R2 R3 directed boundaries (W = 3C)
    apply(1, 1, 0, 8'hC4, 0, 0, 0, 0, 0);   // sum 100: C, DC, Z
    apply(1, 1, 0, 8'h03, 1, 1, 1, 0, 0);   // no carries
    apply(2, 1, 0, 8'h3C, 0, 0, 0, 0, 0);   // equal: C=1 DC=1 Z=1
    apply(2, 1, 0, 8'h3B, 1, 1, 0, 0, 0);   // borrow everywhere
    apply(2, 0, 8'h40, 0, 0, 0, 0, 0, 0);   // low-nibble borrow only
    apply(7, 0, 8'hFF, 0, 0, 0, 0, 0, 0);   // R6 wrap to 0
    apply(8, 0, 8'h00, 0, 0, 0, 1, 0, 0);   // R6 wrap to FF
    apply(9, 0, 8'h80, 0, 1, 1, 1, 0, 0);   // R7
    apply(10, 0, 8'h01, 0, 1, 0, 0, 0, 0);  // R7
    apply(11, 0, 8'hA5, 0, 1, 1, 1, 0, 0);  // R8
    apply(14, 0, 8'h00, 0, 0, 1, 0, 1, 0);  // R8 reserved, file write
    apply(6, 0, 8'hFF, 0, 1, 0, 0, 1, 1);   // R5 complement -> W = 00
    apply(12, 0, 8'h55, 0, 0, 0, 0, 0, 0);  // R8 move W
    for (int i = 0; i < 400; i++) begin
      int o = int'($urandom_range(0, 15));
      apply(o, 1'($urandom), int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    @(negedge clk); #1;
    chk("R10", "final w_val", w_val, w_model);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule